// File: doc/BRIEF.md
# Paired-Port Register Address Pointer

This block holds the register pointer of a two-port register file of 22 registers, grouped as 11 pairs with one member for port A and one for port B. A register-address byte loads the pointer. Each completed data byte then moves the pointer according to the current mode. The block decodes the pointer into a register index, which the register storage uses to select its entry. It also flags addresses that reach no register.

The mode comes from two configuration bits. These are latched into a small state machine only when `cfg_load` is high. The bank bit chooses between two address layouts. In the interleaved layout, the A and B members of a pair sit at neighbouring addresses. In the split layout, all A registers come first and all B registers follow in a second block. The sequential-off bit chooses how the pointer moves. With the bit clear, the pointer steps forward. With the bit set, the pointer either stays put (split layout) or swaps between the two members of its pair (interleaved layout).

The state machine has four states:

| State | Bank bit | Sequential-off bit | Effect of a data byte |
|-------|----------|--------------------|-----------------------|
| MODE_SEQ_ILV | 0 | 0 | pointer steps forward |
| MODE_SEQ_SPLIT | 1 | 0 | pointer steps forward |
| MODE_HOLD_SPLIT | 1 | 1 | pointer stays put |
| MODE_TOGGLE_ILV | 0 | 1 | pointer swaps within its pair |

Reset enters MODE_SEQ_ILV. A `cfg_load` pulse moves the machine from any state to the state named by {`cfg_bank`, `cfg_seq_off`}, including the state it is already in. Without that pulse the state is held.

Top module: `pair_reg_pointer`

## Requirements
- R1: Reset leaves `ptr_q` at 00h and the mode at MODE_SEQ_ILV, so that the first data byte after reset moves the pointer to 01h.
- R2: In every mode, a cycle with `ptr_load` high writes `ptr_addr` into `ptr_q` at that clock edge. This holds even when `acc_step` is high in the same cycle.
- R3: `reg_idx` equals 2*pair + port, where port A is 0 and port B is 1. The pairs are numbered 0 to 10 in this order: direction, input polarity, change-interrupt enable, compare default, interrupt control, configuration, pull-up, interrupt flag, interrupt capture, port value, output latch. In the interleaved layout, addresses 00h–15h hold the pairs, with A at the even address and B at the odd address.
- R4: In the split layout, A registers of pairs 0 to 10 sit at 00h–0Ah and B registers sit at 10h–1Ah.
- R5: Both addresses of the configuration pair decode to index 10. These addresses are 0Ah and 0Bh in the interleaved layout, and 05h and 15h in the split layout.
- R6: Addresses that reach no register give `reg_hit` = 0 and `reg_idx` = 0. These are above 15h in the interleaved layout, and 0Bh–0Fh or above 1Ah in the split layout.
- R7: In the sequential modes, each `acc_step` without `ptr_load` adds one to the pointer. In the split layout this includes stepping through the unmapped gap 0Bh–0Fh.
- R8: In the sequential modes, a step from the last address (15h interleaved, 1Ah split) or from any higher address sets the pointer to 00h.
- R9: In MODE_HOLD_SPLIT, `acc_step` leaves the pointer unchanged.
- R10: In MODE_TOGGLE_ILV, each `acc_step` inverts pointer bit 0, so the pointer alternates between the two members of its pair. This works whether the burst starts on the A member or the B member.
- R11: The mode changes only on a `cfg_load` cycle. A mode change leaves the pointer value unchanged.
- R12: In a cycle with neither `ptr_load` nor `acc_step`, the pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Latch the two mode bits this cycle |
| cfg_bank | input | 1 | Layout select: 0 interleaved, 1 split |
| cfg_seq_off | input | 1 | 0 advance on each byte, 1 hold or toggle |
| ptr_load | input | 1 | Register-address byte received |
| ptr_addr | input | 8 | Register address to load |
| acc_step | input | 1 | One data byte completed |
| ptr_q | output | 8 | Current pointer value |
| reg_idx | output | 5 | Selected register index (2*pair + port) |
| reg_hit | output | 1 | Pointer addresses a mapped register |

## Verification
The hardest corners to reach from the ports are the wrap to 00h and the walk through the unmapped gap of the split layout. Both need the mode latched first and then a pointer placed just before the boundary. The bench therefore latches each mode with a single `cfg_load` pulse, loads an address one or two steps short of the edge, and steps byte by byte. After each step it checks both the pointer and the decoded index. A separate scenario drives new mode bits without `cfg_load` and shows that the old wrap point still applies.

// File: rtl/pair_ptr_pkg.sv
package pair_ptr_pkg;
    localparam int ADDR_W    = 8;
    localparam int IDX_W     = 5;
    localparam int NUM_PAIRS = 11;
    localparam int B_BASE    = 16;
    localparam int CFG_PAIR  = 5;

    typedef enum logic [1:0] {
        MODE_SEQ_ILV    = 2'b00,
        MODE_TOGGLE_ILV = 2'b01,
        MODE_SEQ_SPLIT  = 2'b10,
        MODE_HOLD_SPLIT = 2'b11
    } ptr_mode_e;
endpackage

// File: rtl/ptr_mode_fsm.sv
module ptr_mode_fsm
    import pair_ptr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_load,
    input  logic      cfg_bank,
    input  logic      cfg_seq_off,
    output ptr_mode_e mode_q,
    output logic      split_o
);
    ptr_mode_e mode_d;

    always_comb begin
        mode_d = mode_q;
        if (cfg_load) begin
            unique case ({cfg_bank, cfg_seq_off})
                2'b00: mode_d = MODE_SEQ_ILV;
                2'b01: mode_d = MODE_TOGGLE_ILV;
                2'b10: mode_d = MODE_SEQ_SPLIT;
                2'b11: mode_d = MODE_HOLD_SPLIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_SEQ_ILV;
        else        mode_q <= mode_d;
    end

    always_comb begin
        unique case (mode_q)
            MODE_SEQ_ILV, MODE_TOGGLE_ILV:   split_o = 1'b0;
            MODE_SEQ_SPLIT, MODE_HOLD_SPLIT: split_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/ptr_advance.sv
module ptr_advance
    import pair_ptr_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int PAIRS = NUM_PAIRS,
    parameter int BBASE = B_BASE
) (
    input  ptr_mode_e      mode,
    input  logic [AW-1:0]  ptr,
    output logic [AW-1:0]  ptr_next
);
    localparam logic [AW-1:0] ILV_LAST = AW'(2 * PAIRS - 1);
    localparam logic [AW-1:0] SPL_LAST = AW'(BBASE + PAIRS - 1);

    logic [AW-1:0] ptr_inc;
    assign ptr_inc = ptr + AW'(1);

    always_comb begin
        unique case (mode)
            MODE_SEQ_ILV:    ptr_next = (ptr >= ILV_LAST) ? '0 : ptr_inc;
            MODE_SEQ_SPLIT:  ptr_next = (ptr >= SPL_LAST) ? '0 : ptr_inc;
            MODE_HOLD_SPLIT: ptr_next = ptr;
            MODE_TOGGLE_ILV: ptr_next = {ptr[AW-1:1], ~ptr[0]};
        endcase
    end
endmodule

// File: rtl/ptr_decode.sv
module ptr_decode
    import pair_ptr_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int IW    = IDX_W,
    parameter int PAIRS = NUM_PAIRS,
    parameter int BBASE = B_BASE,
    parameter int CPAIR = CFG_PAIR
) (
    input  logic          split,
    input  logic [AW-1:0] addr,
    output logic [IW-1:0] idx,
    output logic          hit
);
    localparam logic [AW-1:0] ILV_LAST = AW'(2 * PAIRS - 1);
    localparam logic [AW-1:0] A_LAST   = AW'(PAIRS - 1);
    localparam logic [AW-1:0] B_FIRST  = AW'(BBASE);
    localparam logic [AW-1:0] B_LAST   = AW'(BBASE + PAIRS - 1);
    localparam logic [AW-1:0] CFG_P    = AW'(CPAIR);

    logic [AW-1:0] pair;
    logic          port;

    always_comb begin
        hit  = 1'b0;
        pair = '0;
        port = 1'b0;
        if (!split) begin
            if (addr <= ILV_LAST) begin
                hit  = 1'b1;
                pair = {1'b0, addr[AW-1:1]};
                port = addr[0];
            end
        end else if (addr <= A_LAST) begin
            hit  = 1'b1;
            pair = addr;
        end else if (addr >= B_FIRST && addr <= B_LAST) begin
            hit  = 1'b1;
            pair = addr - B_FIRST;
            port = 1'b1;
        end
    end

    always_comb begin
        if (!hit)              idx = '0;
        else if (pair == CFG_P) idx = {pair[IW-2:0], 1'b0};
        else                   idx = {pair[IW-2:0], port};
    end
endmodule

// File: rtl/pair_reg_pointer.sv
module pair_reg_pointer
    import pair_ptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic              cfg_bank,
    input  logic              cfg_seq_off,
    input  logic              ptr_load,
    input  logic [ADDR_W-1:0] ptr_addr,
    input  logic              acc_step,
    output logic [ADDR_W-1:0] ptr_q,
    output logic [IDX_W-1:0]  reg_idx,
    output logic              reg_hit
);
    ptr_mode_e         mode_q;
    logic              split;
    logic [ADDR_W-1:0] ptr_next;

    ptr_mode_fsm u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_load    (cfg_load),
        .cfg_bank    (cfg_bank),
        .cfg_seq_off (cfg_seq_off),
        .mode_q      (mode_q),
        .split_o     (split)
    );

    ptr_advance #(.AW(ADDR_W), .PAIRS(NUM_PAIRS), .BBASE(B_BASE)) u_adv (
        .mode     (mode_q),
        .ptr      (ptr_q),
        .ptr_next (ptr_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)        ptr_q <= '0;
        else if (ptr_load) ptr_q <= ptr_addr;
        else if (acc_step) ptr_q <= ptr_next;
    end

    ptr_decode #(
        .AW(ADDR_W), .IW(IDX_W), .PAIRS(NUM_PAIRS), .BBASE(B_BASE), .CPAIR(CFG_PAIR)
    ) u_dec (
        .split (split),
        .addr  (ptr_q),
        .idx   (reg_idx),
        .hit   (reg_hit)
    );
endmodule

// File: rtl/pair_reg_pointer_chk.sv
module pair_reg_pointer_chk
    import pair_ptr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ptr_load,
    input logic [ADDR_W-1:0] ptr_addr,
    input logic              acc_step,
    input logic [ADDR_W-1:0] ptr_q,
    input logic              reg_hit,
    input ptr_mode_e         mode_q
);
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_load |=> ptr_q == $past(ptr_addr));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_HOLD_SPLIT && acc_step && !ptr_load) |=> $stable(ptr_q));

    p_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_TOGGLE_ILV && acc_step && !ptr_load)
        |=> ptr_q == ($past(ptr_q) ^ 8'h01));

    p_wrap_ilv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SEQ_ILV && acc_step && !ptr_load && ptr_q == 8'h15)
        |=> ptr_q == 8'h00);

    p_gap_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == MODE_SEQ_SPLIT || mode_q == MODE_HOLD_SPLIT)
         && ptr_q >= 8'h0B && ptr_q <= 8'h0F) |-> !reg_hit);

    p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_load && !acc_step) |=> $stable(ptr_q));
endmodule

bind pair_reg_pointer pair_reg_pointer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ptr_load (ptr_load),
    .ptr_addr (ptr_addr),
    .acc_step (acc_step),
    .ptr_q    (ptr_q),
    .reg_hit  (reg_hit),
    .mode_q   (mode_q)
);

// File: tb/pair_reg_pointer_tb.sv
module pair_reg_pointer_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load = 1'b0, cfg_bank = 1'b0, cfg_seq_off = 1'b0;
    logic       ptr_load = 1'b0, acc_step = 1'b0;
    logic [7:0] ptr_addr = '0;
    logic [7:0] ptr_q;
    logic [4:0] reg_idx;
    logic       reg_hit;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 0;
    bit  cur_split = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pair_reg_pointer u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_bank(cfg_bank),
        .cfg_seq_off(cfg_seq_off), .ptr_load(ptr_load), .ptr_addr(ptr_addr),
        .acc_step(acc_step), .ptr_q(ptr_q), .reg_idx(reg_idx), .reg_hit(reg_hit)
    );

    // expected {hit, idx} from the address maps in the requirements
    function automatic logic [5:0] model(input bit split, input logic [7:0] a);
        int p = -1;
        int port = 0;
        if (!split) begin
            if (a <= 8'h15) begin p = int'(a) / 2; port = int'(a) % 2; end
        end else if (a <= 8'h0A) p = int'(a);
        else if (a >= 8'h10 && a <= 8'h1A) begin p = int'(a) - 16; port = 1; end
        if (p < 0)  return 6'd0;
        if (p == 5) return {1'b1, 5'd10};
        return {1'b1, 5'(2 * p + port)};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_at(input string tag, input logic [7:0] exp_ptr);
        logic [5:0] m;
        m = model(cur_split, exp_ptr);
        chk(tag, int'(ptr_q), int'(exp_ptr));
        chk(tag, int'({reg_hit, reg_idx}), int'(m));
    endtask

    // all drivers change at the falling edge; one rising edge per call
    task automatic tick();
        @(negedge clk);
        ptr_load = 0; acc_step = 0; cfg_load = 0;
    endtask

    task automatic load(input logic [7:0] a);
        ptr_load = 1; ptr_addr = a; tick();
    endtask

    task automatic step();
        acc_step = 1; tick();
    endtask

    task automatic set_mode(input bit bank, input bit off);
        cfg_bank = bank; cfg_seq_off = off; cfg_load = 1; tick();
        cur_split = bank;
    endtask

    task automatic t_reset();
        expect_at("R1 reset", 8'h00);
        step();
        expect_at("R1 default sequential", 8'h01);
    endtask

    task automatic t_ilv_decode();
        load(8'h12); expect_at("R3 port value A", 8'h12);
        chk("R3 idx", int'(reg_idx), 18);
        load(8'h13); expect_at("R3 port value B", 8'h13);
        load(8'h01); expect_at("R3 direction B", 8'h01);
        load(8'h0A); expect_at("R5 cfg even", 8'h0A);
        chk("R5 idx", int'(reg_idx), 10);
        load(8'h0B); expect_at("R5 cfg odd", 8'h0B);
        chk("R5 idx", int'(reg_idx), 10);
        load(8'h16); expect_at("R6 above ilv", 8'h16);
        chk("R6 miss", int'(reg_hit), 0);
    endtask

    task automatic t_split_decode();
        load(8'h09);
        set_mode(1'b1, 1'b0);
        expect_at("R11 ptr kept over mode change", 8'h09);
        chk("R4 idx", int'(reg_idx), 18);
        load(8'h19); expect_at("R4 B port value", 8'h19);
        chk("R4 idx", int'(reg_idx), 19);
        load(8'h05); expect_at("R5 split A", 8'h05);
        load(8'h15); expect_at("R5 split B", 8'h15);
        chk("R5 idx", int'(reg_idx), 10);
        load(8'h0C); expect_at("R6 gap", 8'h0C);
        load(8'h1B); expect_at("R6 above split", 8'h1B);
        chk("R6 miss", int'(reg_hit), 0);
    endtask

    task automatic t_seq_walk();
        load(8'h09);
        step(); expect_at("R7 step", 8'h0A);
        step(); expect_at("R7 into gap", 8'h0B);
        step(); expect_at("R7 through gap", 8'h0C);
        load(8'h1A);
        step(); expect_at("R8 split wrap", 8'h00);
        load(8'h40);
        step(); expect_at("R8 wrap from beyond", 8'h00);
        set_mode(1'b0, 1'b0);
        load(8'h14);
        step(); expect_at("R7 ilv step", 8'h15);
        step(); expect_at("R8 ilv wrap", 8'h00);
    endtask

    task automatic t_hold();
        set_mode(1'b1, 1'b1);
        load(8'h12);
        for (int i = 0; i < 3; i++) begin
            step(); expect_at("R9 hold", 8'h12);
        end
    endtask

    task automatic t_toggle();
        set_mode(1'b0, 1'b1);
        load(8'h13);
        step(); expect_at("R10 B to A", 8'h12);
        step(); expect_at("R10 A to B", 8'h13);
        load(8'h04);
        step(); expect_at("R10 start A", 8'h05);
    endtask

    task automatic t_load_priority();
        acc_step = 1; ptr_load = 1; ptr_addr = 8'h0E; tick();
        expect_at("R2 load beats step", 8'h0E);
    endtask

    task automatic t_idle();
        tick(); tick(); tick();
        expect_at("R12 idle", 8'h0E);
    endtask

    task automatic t_cfg_needs_load();
        set_mode(1'b0, 1'b0);
        cfg_bank = 1; cfg_seq_off = 1;
        load(8'h15);
        step(); expect_at("R11 mode held without cfg_load", 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_ilv_decode();
        t_split_decode();
        t_seq_walk();
        t_hold();
        t_toggle();
        t_load_priority();
        t_idle();
        t_cfg_needs_load();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule